// File: doc/BRIEF.md
# Burst address generator

This block keeps the registered address used by a synchronous burst memory controller. When the controller starts a new cycle, it pulses a load strobe with the full external address. The block captures that address and also records whether the burst is a write. Each later qualified advance moves only the two lowest address bits to the next of four beats. The order of the beats is set by a static order input: linear (count up, wrapping modulo 4) or interleaved (start value XOR beat number). A cycle without a qualified advance holds the address.

The upper address bits stay frozen for the whole burst and never take a carry from the low bits. After four advances the low bits return to the loaded value. A new load at any point restarts the burst at once. The advance input is not looked at in a load cycle. In a write burst, an advance counts only while a byte write enable is also active. Strobe arbitration and memory access are left to the surrounding controller.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after its release with no other activity, addr_o is 0.
- R2: When load_i is 1 at a rising clock edge, addr_o equals addr_i from the following cycle on, and the beat count restarts at 0.
- R3: With order_i = 1 (interleaved), the low two bits after the n-th advance of a burst equal the loaded low bits XOR n (n mod 4). For example, start 01 gives 01, 00, 11, 10.
- R4: With order_i = 0 (linear), the low two bits after the n-th advance equal (loaded low bits + n) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R5: After four advances the low bits are back at the loaded value. The upper ADDR_W-2 bits never change between loads, including when the low bits wrap from 11 to 00 with all upper bits set.
- R6: A cycle with load_i = 0 and adv_i = 0 leaves addr_o unchanged.
- R7: In a burst loaded with load_wr_i = 1, an advance happens only when adv_i and byte_wen_i are both 1. In a burst loaded with load_wr_i = 0, byte_wen_i has no effect.
- R8: A load in the middle of a burst replaces the address and restarts the sequence from the newly loaded low bits.
- R9: adv_i has no effect in a load cycle: the loaded address appears unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| order_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| load_i | input | 1 | Start of a cycle: capture addr_i |
| load_wr_i | input | 1 | The burst being loaded is a write (sampled with load_i) |
| addr_i | input | ADDR_W | External address |
| adv_i | input | 1 | Advance request |
| byte_wen_i | input | 1 | At least one byte write enable is active this cycle |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The checker assumes that all inputs are free of X after reset. It also treats order_i as quasi-static, so a step is judged by the order in force in the cycle that made it. The bench changes order_i only in load cycles, and it places suspend cycles and write-gated cycles between beats. Under these conditions each qualified advance yields exactly one defined low-bit step. A reference model built from integers predicts addr_o in every cycle for all four start values in both orders, for reloads in mid-burst, and for a wrap with the upper bits all ones.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned LOW_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_ILV    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_step_ctrl.sv
module bag_step_ctrl
  import bag_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_wr_i,
  input  logic             adv_i,
  input  logic             byte_wen_i,
  output logic             step_o,
  output logic [LOW_W-1:0] beat_nxt_o
);
  logic [LOW_W-1:0] beat_q;
  logic             wr_q;

  // write bursts need a byte strobe to move; load edge ignores adv
  assign step_o     = !load_i && adv_i && (!wr_q || byte_wen_i);
  assign beat_nxt_o = beat_q + LOW_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      wr_q   <= 1'b0;
    end else if (load_i) begin
      beat_q <= '0;
      wr_q   <= load_wr_i;
    end else if (step_o) begin
      beat_q <= beat_nxt_o;
    end
  end
endmodule

// File: rtl/bag_low_next.sv
module bag_low_next
  import bag_pkg::*;
(
  input  logic             order_i,
  input  logic [LOW_W-1:0] start_i,
  input  logic [LOW_W-1:0] beat_i,
  output logic [LOW_W-1:0] low_o
);
  logic [LOW_W-1:0] ilv_low;
  logic [LOW_W-1:0] lin_low;

  for (genvar b = 0; b < LOW_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  assign lin_low = start_i + beat_i;
  assign low_o   = (burst_order_e'(order_i) == ORDER_ILV) ? ilv_low : lin_low;
endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOW_W-1:0]  low_nxt_i,
  output logic [LOW_W-1:0]  start_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned UP_W = ADDR_W - LOW_W;

  logic [UP_W-1:0]  up_q;
  logic [LOW_W-1:0] low_q;
  logic [LOW_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q    <= '0;
      low_q   <= '0;
      start_q <= '0;
    end else if (load_i) begin
      up_q    <= addr_i[ADDR_W-1:LOW_W];
      low_q   <= addr_i[LOW_W-1:0];
      start_q <= addr_i[LOW_W-1:0];
    end else if (step_i) begin
      low_q   <= low_nxt_i;  // upper bits untouched: no carry out of burst
    end
  end

  assign start_o = start_q;
  assign addr_o  = {up_q, low_q};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              order_i,
  input  logic              load_i,
  input  logic              load_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              byte_wen_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic             step;
  logic [LOW_W-1:0] beat_nxt;
  logic [LOW_W-1:0] start;
  logic [LOW_W-1:0] low_nxt;

  bag_step_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_wr_i  (load_wr_i),
    .adv_i      (adv_i),
    .byte_wen_i (byte_wen_i),
    .step_o     (step),
    .beat_nxt_o (beat_nxt)
  );

  bag_low_next i_low (
    .order_i (order_i),
    .start_i (start),
    .beat_i  (beat_nxt),
    .low_o   (low_nxt)
  );

  bag_addr_reg #(.ADDR_W(ADDR_W)) i_areg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .step_i    (step),
    .addr_i    (addr_i),
    .low_nxt_i (low_nxt),
    .start_o   (start),
    .addr_o    (addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              order_i,
  input logic              load_i,
  input logic              load_wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adv_i,
  input logic              byte_wen_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic       wr_q;
  logic [1:0] cnt_q;
  logic       adv_ok;

  assign adv_ok = !load_i && adv_i && (!wr_q || byte_wen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else if (load_i) begin
      wr_q  <= load_wr_i;
      cnt_q <= 2'd0;
    end else if (adv_ok) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (addr_o == '0);
  end

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));

  a_r3_ilv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_ok && order_i) |=>
      ((addr_o[1:0] ^ $past(addr_o[1:0])) == ($past(cnt_q) ^ 2'($past(cnt_q) + 2'd1))));

  a_r4_lin_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_ok && !order_i) |=> addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1));

  a_r5_upper_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:2]));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_o));

  a_r7_wr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && wr_q && !byte_wen_i) |=> $stable(addr_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .order_i    (order_i),
  .load_i     (load_i),
  .load_wr_i  (load_wr_i),
  .addr_i     (addr_i),
  .adv_i      (adv_i),
  .byte_wen_i (byte_wen_i),
  .addr_o     (addr_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 19;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          order_i = 1'b0;
  logic          load_i = 1'b0;
  logic          load_wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adv_i = 1'b0;
  logic          byte_wen_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int            m_start = 0;
  int            m_n = 0;
  bit            m_wr = 0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk_i (clk_i), .rst_ni (rst_ni), .order_i (order_i), .load_i (load_i),
    .load_wr_i (load_wr_i), .addr_i (addr_i), .adv_i (adv_i),
    .byte_wen_i (byte_wen_i), .addr_o (addr_o)
  );

  task automatic check(input string tag);
    checks++;
    if (addr_o !== m_addr) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, m_addr);
    end
  endtask

  task automatic step(input bit ld, input logic [AW-1:0] a, input bit lw,
                      input bit adv, input bit bw, input bit ord, input string tag);
    int low;
    @(negedge clk_i);
    load_i = ld; addr_i = a; load_wr_i = lw; adv_i = adv; byte_wen_i = bw; order_i = ord;
    @(posedge clk_i);
    if (ld) begin
      m_addr = a; m_start = int'(a[1:0]); m_n = 0; m_wr = lw;
    end else if (adv && (!m_wr || bw)) begin
      m_n = (m_n + 1) % 4;
      low = ord ? (m_start ^ m_n) : ((m_start + m_n) % 4);
      m_addr[1:0] = 2'(low);
    end
    #1;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: addr_o=%h expected=finish", addr_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    string tg;
    repeat (3) @(negedge clk_i);
    #1 check("R1");
    rst_ni = 1'b1;
    @(posedge clk_i); #1 check("R1");

    for (int o = 0; o < 2; o++) begin
      tg = (o == 1) ? "R3" : "R4";
      for (int s = 0; s < 4; s++) begin
        base = {17'(17'h1ABCD ^ (s * 977 + o * 31)), 2'(s)};
        step(1, base, 0, 1, 0, o[0], "R9");       // adv on load edge ignored
        step(0, '0, 0, 1, 0, o[0], tg);
        step(0, '0, 0, 0, 0, o[0], "R6");          // suspend
        step(0, '0, 0, 1, 1, o[0], tg);            // read burst: byte_wen ignored (R7)
        step(0, '0, 0, 0, 1, o[0], "R6");
        step(0, '0, 0, 1, 0, o[0], tg);
        step(0, '0, 0, 1, 0, o[0], "R5");          // back to start
        step(0, '0, 0, 1, 0, o[0], tg);
      end
    end

    // wrap with upper bits all ones, linear
    step(1, '1, 0, 0, 0, 0, "R2");
    step(0, '0, 0, 1, 0, 0, "R5");
    step(0, '0, 0, 1, 0, 0, "R5");
    // same, interleaved
    step(1, '1, 0, 0, 0, 1, "R2");
    step(0, '0, 0, 1, 0, 1, "R5");
    step(0, '0, 0, 1, 0, 1, "R5");

    // write burst gating
    step(1, 19'h2_4561, 1, 0, 0, 1, "R2");
    step(0, '0, 0, 1, 0, 1, "R7");
    step(0, '0, 0, 1, 1, 1, "R7");
    step(0, '0, 0, 1, 0, 1, "R7");
    step(0, '0, 0, 1, 1, 1, "R7");
    step(0, '0, 0, 0, 1, 1, "R6");

    // reload mid-burst restarts sequence
    step(1, 19'h0_1232, 0, 0, 0, 0, "R2");
    step(0, '0, 0, 1, 0, 0, "R4");
    step(1, 19'h5_5553, 0, 1, 0, 0, "R8");
    step(0, '0, 0, 1, 0, 0, "R8");
    step(0, '0, 0, 1, 0, 0, "R8");
    step(1, 19'h3_0001, 0, 0, 0, 1, "R8");
    step(0, '0, 0, 1, 0, 1, "R8");
    step(0, '0, 0, 1, 0, 1, "R3");
    step(0, '0, 0, 1, 0, 1, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule